// File: doc/BRIEF.md
# Iterative 64-bit Integer Multiplier with Upper-Half Results

This unit multiplies two 64-bit register operands one multiplier bit per clock, using a shift-and-add datapath with a 65-bit adder. A 3-bit operation selector and a word-mode flag pick what is returned. The choices are the low 64 bits of the product, or the upper 64 bits of the 128-bit product with both operands signed, both unsigned, or the first signed and the second unsigned. Word mode returns the 32-bit product of the low operand halves, sign-extended.

Signed operands are turned into magnitudes before the iteration. The 128-bit magnitude product is negated at the end when the operand signs differ, so every result is exact, including when an operand is the most negative value. A core drives `start` for one cycle with the operands. It waits for the one-cycle `done` pulse and then reads `result`, which holds its value until the next operation completes.

Top module: `imul_engine`

## Requirements
- R1: Selector value 0 returns bits 63:0 of the product of the two operands.
- R2: Selector value 1 interprets both operands as two's-complement signed and returns bits 127:64 of the 128-bit product.
- R3: Selector value 2 interprets operand A as signed and operand B as unsigned and returns bits 127:64 of the 128-bit product.
- R4: Selector value 3 interprets both operands as unsigned and returns bits 127:64 of the 128-bit product.
- R5: Selector values 4 to 7 behave exactly like value 0 (low 64 bits).
- R6: With word mode high, the selector is ignored: bits 31:0 of both operands are multiplied, and bits 31:0 of that product, sign-extended from bit 31, form the 64-bit result.
- R7: Upper-half results are exact two's-complement values when either or both operands equal 0x8000_0000_0000_0000.
- R8: A start seen while idle captures the operands, the selector and word mode. Busy is high from the next cycle. Done is high for exactly one cycle, 65 clock edges after the start edge (33 in word mode), with busy low in that cycle. The result holds its value between done pulses.
- R9: A start asserted while busy is ignored: the running operation finishes at its own time with its own result.
- R10: Synchronous active-high reset, also during an operation, makes busy and done low and the result zero.
- R11: Changing the operand, selector or word-mode inputs after the start edge has no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| funct3 | input | 3 | Operation selector (see R1 to R5) |
| word_mode | input | 1 | Select the 32-bit sign-extended product |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Operand B |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| result | output | 64 | Selected result, held until the next completion |

## Verification
A full-width operation shows done 65 edges after the start edge and a word operation 33 edges after it. The bench drives start at a falling edge and counts falling edges until done appears. A pulse that comes early or late fails on the count, not on the value. The result is read in the done cycle and again one cycle later to confirm it holds. Operands are scrambled, and a second start is injected, while the unit is busy, so that capture and the ignored start are both checked against the first operation's expected value.

// File: rtl/imul_pkg.sv
package imul_pkg;

    typedef enum logic [1:0] {
        HALF_LOW  = 2'd0,
        HALF_HIGH = 2'd1,
        HALF_WORD = 2'd2
    } res_sel_e;

    typedef struct packed {
        logic     a_signed;
        logic     b_signed;
        res_sel_e sel;
    } mul_ctl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_FIX  = 2'd2
    } mul_state_e;

    function automatic mul_ctl_t decode_op(input logic [2:0] f3, input logic word);
        mul_ctl_t c;
        c = '{a_signed: 1'b0, b_signed: 1'b0, sel: HALF_LOW};
        if (word) begin
            c.sel = HALF_WORD;
        end else begin
            case (f3)
                3'd1: c = '{a_signed: 1'b1, b_signed: 1'b1, sel: HALF_HIGH};
                3'd2: c = '{a_signed: 1'b1, b_signed: 1'b0, sel: HALF_HIGH};
                3'd3: c = '{a_signed: 1'b0, b_signed: 1'b0, sel: HALF_HIGH};
                default: c = '{a_signed: 1'b0, b_signed: 1'b0, sel: HALF_LOW};
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/imul_operand_prep.sv
module imul_operand_prep
    import imul_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned WLEN = 32
) (
    input  logic [XLEN-1:0] a_in,
    input  logic [XLEN-1:0] b_in,
    input  mul_ctl_t        ctl,
    output logic [XLEN-1:0] a_mag,
    output logic [XLEN-1:0] b_mag,
    output logic            neg
);
    localparam int unsigned PADW = XLEN - WLEN;

    logic a_is_neg;
    logic b_is_neg;

    always_comb begin
        a_is_neg = ctl.a_signed & a_in[XLEN-1];
        b_is_neg = ctl.b_signed & b_in[XLEN-1];
        neg      = a_is_neg ^ b_is_neg;
        if (ctl.sel == HALF_WORD) begin
            a_mag = {{PADW{1'b0}}, a_in[WLEN-1:0]};
            b_mag = {{PADW{1'b0}}, b_in[WLEN-1:0]};
        end else begin
            a_mag = a_is_neg ? (~a_in + 1'b1) : a_in;
            b_mag = b_is_neg ? (~b_in + 1'b1) : b_in;
        end
    end
endmodule

// File: rtl/imul_shift_add.sv
module imul_shift_add #(
    parameter int unsigned XLEN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [XLEN-1:0]   mcand,
    input  logic [XLEN-1:0]   mplier,
    output logic [2*XLEN-1:0] prod
);
    logic [XLEN-1:0] mcand_q;
    logic [XLEN-1:0] hi_q;
    logic [XLEN-1:0] lo_q;
    logic [XLEN:0]   sum;

    always_comb begin
        sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else if (load) begin
            mcand_q <= mcand;
            hi_q    <= '0;
            lo_q    <= mplier;
        end else if (step) begin
            {hi_q, lo_q} <= {sum, lo_q[XLEN-1:1]};
        end
    end

    assign prod = {hi_q, lo_q};
endmodule

// File: rtl/imul_result_fix.sv
module imul_result_fix
    import imul_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned WLEN = 32
) (
    input  logic [2*XLEN-1:0] prod,
    input  logic              neg,
    input  res_sel_e          sel,
    output logic [XLEN-1:0]   res
);
    localparam int unsigned PADW  = XLEN - WLEN;
    localparam int unsigned WBASE = XLEN - WLEN;

    logic [2*XLEN-1:0] prod_s;
    logic [WLEN-1:0]   wprod;

    always_comb begin
        prod_s = neg ? (~prod + 1'b1) : prod;
        wprod  = prod[WBASE +: WLEN];
        case (sel)
            HALF_HIGH: res = prod_s[2*XLEN-1:XLEN];
            HALF_WORD: res = {{PADW{wprod[WLEN-1]}}, wprod};
            default:   res = prod_s[XLEN-1:0];
        endcase
    end
endmodule

// File: rtl/imul_engine.sv
module imul_engine
    import imul_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned WLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [2:0]      funct3,
    input  logic            word_mode,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result
);
    localparam int unsigned CNT_W = $clog2(XLEN + 1);

    mul_state_e        state;
    logic [CNT_W-1:0]  cnt;
    mul_ctl_t          ctl_in;
    mul_ctl_t          ctl_q;
    logic              neg_in;
    logic              neg_q;
    logic [XLEN-1:0]   a_mag;
    logic [XLEN-1:0]   b_mag;
    logic [2*XLEN-1:0] prod;
    logic [XLEN-1:0]   fixed;
    logic [XLEN-1:0]   result_q;
    logic              done_q;
    logic              accept;

    assign ctl_in = decode_op(funct3, word_mode);
    assign accept = (state == ST_IDLE) && start;

    imul_operand_prep #(.XLEN(XLEN), .WLEN(WLEN)) u_prep (
        .a_in  (opnd_a),
        .b_in  (opnd_b),
        .ctl   (ctl_in),
        .a_mag (a_mag),
        .b_mag (b_mag),
        .neg   (neg_in)
    );

    imul_shift_add #(.XLEN(XLEN)) u_core (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .step   (state == ST_STEP),
        .mcand  (a_mag),
        .mplier (b_mag),
        .prod   (prod)
    );

    imul_result_fix #(.XLEN(XLEN), .WLEN(WLEN)) u_fix (
        .prod (prod),
        .neg  (neg_q),
        .sel  (ctl_q.sel),
        .res  (fixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            ctl_q    <= '0;
            neg_q    <= 1'b0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        ctl_q <= ctl_in;
                        neg_q <= neg_in;
                        cnt   <= word_mode ? CNT_W'(WLEN) : CNT_W'(XLEN);
                        state <= ST_STEP;
                    end
                end
                ST_STEP: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == CNT_W'(1)) begin
                        state <= ST_FIX;
                    end
                end
                ST_FIX: begin
                    result_q <= fixed;
                    done_q   <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state != ST_IDLE);
    assign done   = done_q;
    assign result = result_q;
endmodule

// File: rtl/imul_engine_chk.sv
module imul_engine_chk #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned WLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            word_mode,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] result
);
    localparam int unsigned LW = $clog2(XLEN + 2);

    logic          word_cap;
    logic [LW-1:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_cap <= 1'b0;
            busy_len <= '0;
        end else begin
            if (start && !busy) word_cap <= word_mode;
            busy_len <= busy ? busy_len + 1'b1 : '0;
        end
    end

    assert_reset_idle_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_start_takes_R8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_result_held_R8: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> $stable(result));

    assert_busy_bounded_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_len < LW'(XLEN + 1)));

    assert_word_sext_R6: assert property (@(posedge clk) disable iff (rst)
        (done && word_cap) |-> (result[XLEN-1:WLEN] == {(XLEN-WLEN){result[WLEN-1]}}));
endmodule

bind imul_engine imul_engine_chk #(.XLEN(XLEN), .WLEN(WLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .word_mode (word_mode),
    .busy      (busy),
    .done      (done),
    .result    (result)
);

// File: tb/test_imul_engine.sv
`timescale 1ns/1ps
module test_imul_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  funct3 = 3'd0;
    logic        word_mode = 1'b0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        busy;
    logic        done;
    logic [63:0] result;

    int checks = 0;
    int failures = 0;
    logic [63:0] lcg = 64'h1234_5678_9ABC_DEF1;

    localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;

    imul_engine i_imul_engine (
        .clk(clk), .rst(rst), .start(start), .funct3(funct3), .word_mode(word_mode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .busy(busy), .done(done), .result(result)
    );

    always #5 clk = ~clk;

    function automatic logic [63:0] pat(input int k);
        case (k)
            0: return 64'd0;
            1: return 64'd1;
            2: return '1;
            3: return MINV;
            4: return 64'h7FFF_FFFF_FFFF_FFFF;
            5: return 64'd2;
            6: return 64'h0000_0000_FFFF_FFFF;
            7: return 64'h0000_0000_8000_0000;
            8: return 64'hDEAD_BEEF_0123_4567;
            default: return 64'hFFFF_FFFF_FFFF_FFFE;
        endcase
    endfunction

    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic [2:0] f3, input logic w);
        logic [127:0] ea, eb, p;
        logic [63:0]  pw;
        if (w) begin
            pw = {32'd0, a[31:0]} * {32'd0, b[31:0]};
            return {{32{pw[31]}}, pw[31:0]};
        end
        ea = {64'd0, a};
        eb = {64'd0, b};
        if (f3 == 3'd1 || f3 == 3'd2) ea = {{64{a[63]}}, a};
        if (f3 == 3'd1) eb = {{64{b[63]}}, b};
        p = ea * eb;
        if (f3 >= 3'd1 && f3 <= 3'd3) return p[127:64];
        return p[63:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] f3, input logic w,
                                     input logic [63:0] a, input logic [63:0] b);
        string t;
        if (w) t = "R6";
        else if (f3 == 3'd0) t = "R1";
        else if (f3 == 3'd1) t = "R2";
        else if (f3 == 3'd2) t = "R3";
        else if (f3 == 3'd3) t = "R4";
        else t = "R5";
        if (!w && (a == MINV || b == MINV)) t = {t, " R7"};
        return t;
    endfunction

    task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                          input logic [2:0] f3, input logic w, input bit poke);
        logic [63:0] exp;
        int n_exp;
        int seen;
        string t;
        exp   = model(a, b, f3, w);
        n_exp = (w ? 32 : 64) + 2;
        t     = tag_of(f3, w, a, b);
        @(negedge clk);
        start = 1'b1; opnd_a = a; opnd_b = b; funct3 = f3; word_mode = w;
        @(negedge clk);
        // R11: scramble inputs after capture
        start = 1'b0; opnd_a = ~a; opnd_b = a ^ b ^ 64'h55; funct3 = ~f3; word_mode = ~w;
        check(busy == 1'b1, "R8", "busy after start", {63'd0, busy}, 64'd1);
        seen = 0;
        for (int i = 1; i < 100 && seen == 0; i++) begin
            if (done) begin
                seen = i;
            end else begin
                // R9: start while busy must be ignored
                if (poke && i == 5) begin start = 1'b1; opnd_a = 64'd3; opnd_b = 64'd3; end
                if (poke && i == 6) start = 1'b0;
                @(negedge clk);
            end
        end
        check(seen == n_exp, poke ? "R9 R8" : "R8", "done timing", 64'(seen), 64'(n_exp));
        check(result == exp, poke ? {t, " R9 R11"} : {t, " R11"}, "result", result, exp);
        @(negedge clk);
        check(!done && result == exp, "R8", "hold after done", result, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && result == 64'd0, "R10", "reset state", result, 64'd0);

        for (int f = 0; f < 4; f++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    run_op(pat(i), pat(j), 3'(f), 1'b0, 1'b0);

        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
                run_op(pat(i), pat(j), 3'((i + j) % 8), 1'b1, 1'b0);

        for (int f = 4; f < 8; f++)
            for (int i = 0; i < 10; i += 3)
                run_op(pat(i), pat(9 - i), 3'(f), 1'b0, 1'b0);

        for (int k = 0; k < 40; k++) begin
            logic [63:0] ra, rb;
            lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
            ra  = lcg;
            lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
            rb  = lcg;
            run_op(ra, rb, 3'(k % 8), k % 5 == 0, k % 7 == 0);
        end

        run_op(MINV, MINV, 3'd1, 1'b0, 1'b1);
        run_op(MINV, '1, 3'd2, 1'b0, 1'b1);

        // R10: reset in the middle of an operation
        @(negedge clk);
        start = 1'b1; opnd_a = 64'd7; opnd_b = 64'd9; funct3 = 3'd0; word_mode = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && result == 64'd0, "R10", "mid-run reset", result, 64'd0);
        repeat (80) @(negedge clk);
        check(!done && !busy, "R10", "no late done", {63'd0, done}, 64'd0);
        run_op(64'd7, 64'd9, 3'd0, 1'b0, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule